// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical memory address by adding it to one of four 16-bit segment registers. The segment value is moved up by four bit positions before the add. The four registers are code, data, stack and extra, and each has its own write path. Each memory reference states its kind, and for ordinary data also whether the base register was the frame pointer. The block uses these two facts to pick a default segment.

A one-shot segment prefix can be armed ahead of a reference. It steers the next data reference to any segment. Instruction fetches, implicit stack-pointer accesses and string destinations keep their fixed segments whatever the prefix says. The result is registered and appears one cycle after the request, together with a 2-bit code for the segment that was used. Offset arithmetic and effective-address formation happen upstream. I/O port cycles never enter this block.

Top module: `segAddrGen`

## Requirements
- R1: After reset `addrValid` is 0, no prefix is pending, and all four segment registers read as zero, so a data reference gives a physical address equal to its offset.
- R2: One cycle after a cycle with `refValid` high, `addrValid` is 1 and `physAddr` = ((segment << 4) + offset) mod 2^20 for the segment selected.
- R3: A fetch reference (`refKind` = 0) always uses the code segment (`segUsed` = 01). A pending prefix is ignored and stays armed.
- R4: A data reference (`refKind` = 1) with `useBp` low and no pending prefix uses the data segment (`segUsed` = 11).
- R5: A data reference with `useBp` high and no pending prefix uses the stack segment (`segUsed` = 10).
- R6: A stack reference (`refKind` = 2) always uses the stack segment. A pending prefix is ignored and is cleared.
- R7: A string-destination reference (`refKind` = 3) always uses the extra segment (`segUsed` = 00). A pending prefix is ignored and is cleared.
- R8: A data reference made while a prefix is pending uses the segment named by the prefix (`ovrSeg`: 00 extra, 01 code, 10 stack, 11 data). This applies whether `useBp` is high or low.
- R9: A prefix is consumed by the first non-fetch reference after it is armed. A prefix armed in the same cycle as a reference takes effect only from the next reference.
- R10: A segment write (`segWrSel` uses the same coding as `segUsed`) affects only references in later cycles. A reference in the write cycle sees the old value.
- R11: Any carry out of the top address bit is dropped, so segment FFFF with offset FFFF gives 0FFEF.
- R12: In a cycle after one with `refValid` low, `addrValid` is 0 and `physAddr` and `segUsed` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segWrEn | input | 1 | Write strobe for a segment register |
| segWrSel | input | 2 | Segment register to write |
| segWrData | input | 16 | New segment value |
| ovrValid | input | 1 | Arms a one-shot segment prefix |
| ovrSeg | input | 2 | Segment named by the prefix |
| refValid | input | 1 | Memory reference request |
| refKind | input | 2 | 0 fetch, 1 data, 2 stack, 3 string destination |
| useBp | input | 1 | Data reference is based on the frame pointer |
| offset | input | 16 | 16-bit offset within the segment |
| addrValid | output | 1 | Result valid, one cycle after request |
| physAddr | output | 20 | Physical address |
| segUsed | output | 2 | Segment that formed the address |

## Verification
The assertions assume that every input is a defined 0 or 1 at each clock edge while reset is released. They do not assume that any pair of strobes is exclusive, because writes, prefixes and references may all arrive in the same cycle. The stimulus changes inputs only on the falling edge. It deliberately combines a segment write or a new prefix with a reference in one cycle, so that the rules for the old value and the late prefix are exercised.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } segId_e;

  typedef enum logic [1:0] {
    REF_FETCH  = 2'b00,
    REF_DATA   = 2'b01,
    REF_STACK  = 2'b10,
    REF_STRDST = 2'b11
  } refKind_e;

  typedef struct packed {
    logic   capture;
    segId_e segSel;
  } segStrobe_t;
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segaddr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ovrValid,
  input  logic [1:0] ovrSeg,
  input  logic       refValid,
  input  logic [1:0] refKind,
  input  logic       useBp,
  output segStrobe_t strobe
);
  logic     pendValid;
  segId_e   pendSeg;
  refKind_e kind;
  segId_e   selSeg;
  logic     consumes;

  assign kind     = refKind_e'(refKind);
  assign consumes = refValid && (kind != REF_FETCH);

  always_comb begin
    unique case (kind)
      REF_FETCH:  selSeg = SEG_CODE;
      REF_STACK:  selSeg = SEG_STACK;
      REF_STRDST: selSeg = SEG_EXTRA;
      default: begin
        if (pendValid)  selSeg = pendSeg;
        else if (useBp) selSeg = SEG_STACK;
        else            selSeg = SEG_DATA;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendSeg   <= SEG_EXTRA;
    end else if (ovrValid) begin
      pendValid <= 1'b1;
      pendSeg   <= segId_e'(ovrSeg);
    end else if (consumes) begin
      pendValid <= 1'b0;
    end
  end

  assign strobe.capture = refValid;
  assign strobe.segSel  = selSeg;

  // R9
  prefix_consumed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (consumes && !ovrValid) |=> !pendValid);

  // R3
  fetch_keeps_prefix_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && refValid && kind == REF_FETCH && !ovrValid) |=> pendValid && $stable(pendSeg));
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segaddr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int NSEG  = 4,
  localparam int ADDR_W = SEG_W + SHIFT,
  localparam int SEL_W  = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobe_t        strobe,
  input  logic              segWrEn,
  input  logic [SEL_W-1:0]  segWrSel,
  input  logic [SEG_W-1:0]  segWrData,
  input  logic [OFF_W-1:0]  offset,
  output logic              addrValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic [SEL_W-1:0]  segUsed
);
  logic [SEG_W-1:0]  segBank [NSEG];
  logic [SEG_W-1:0]  segVal;
  logic [ADDR_W-1:0] sum;

  for (genvar g = 0; g < NSEG; g++) begin : gSeg
    always_ff @(posedge clk) begin
      if (!rstN)                                      segBank[g] <= '0;
      else if (segWrEn && segWrSel == SEL_W'(g))      segBank[g] <= segWrData;
    end
  end

  assign segVal = segBank[strobe.segSel];
  assign sum    = {segVal, {SHIFT{1'b0}}} + ADDR_W'(offset);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      physAddr  <= '0;
      segUsed   <= '0;
    end else begin
      addrValid <= strobe.capture;
      if (strobe.capture) begin
        physAddr <= sum;
        segUsed  <= SEL_W'(strobe.segSel);
      end
    end
  end

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> addrValid);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !addrValid && $stable(physAddr) && $stable(segUsed));
endmodule

// File: rtl/segAddrGen.sv
module segAddrGen
  import segaddr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        segWrEn,
  input  logic [1:0]  segWrSel,
  input  logic [15:0] segWrData,
  input  logic        ovrValid,
  input  logic [1:0]  ovrSeg,
  input  logic        refValid,
  input  logic [1:0]  refKind,
  input  logic        useBp,
  input  logic [15:0] offset,
  output logic        addrValid,
  output logic [19:0] physAddr,
  output logic [1:0]  segUsed
);
  segStrobe_t strobe;

  segCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .ovrValid(ovrValid), .ovrSeg(ovrSeg),
    .refValid(refValid), .refKind(refKind), .useBp(useBp), .strobe(strobe)
  );

  segDatapath #(.SEG_W(16), .OFF_W(16), .SHIFT(4), .NSEG(4)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .segWrEn(segWrEn),
    .segWrSel(segWrSel), .segWrData(segWrData), .offset(offset),
    .addrValid(addrValid), .physAddr(physAddr), .segUsed(segUsed)
  );

  // R3
  fetch_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refKind == 2'b00) |=> segUsed == 2'b01);

  // R6
  stack_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refKind == 2'b10) |=> segUsed == 2'b10);

  // R7
  strdst_extra_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refKind == 2'b11) |=> segUsed == 2'b00);
endmodule

// File: tb/segAddrGen_tb.sv
`timescale 1ns/1ps
module segAddrGen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrSel = '0;
  logic [15:0] segWrData = '0;
  logic        ovrValid = 1'b0;
  logic [1:0]  ovrSeg = '0;
  logic        refValid = 1'b0;
  logic [1:0]  refKind = '0;
  logic        useBp = 1'b0;
  logic [15:0] offset = '0;
  logic        addrValid;
  logic [19:0] physAddr;
  logic [1:0]  segUsed;

  always #2 clk = ~clk;

  segAddrGen dut_i (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int segM [4];
  bit pendM = 0;
  int pendSegM = 0;
  bit expValid = 0;
  int expAddr = 0;
  int expSeg = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model();
    int sel;
    if (refValid) begin
      case (refKind)
        2'd0: sel = 1;
        2'd2: sel = 2;
        2'd3: sel = 0;
        default: sel = pendM ? pendSegM : (useBp ? 2 : 3);
      endcase
      expAddr  = ((segM[sel] << 4) + offset) & 20'hFFFFF;
      expSeg   = sel;
      expValid = 1;
      if (refKind != 2'd0) pendM = 0;
    end else begin
      expValid = 0;
    end
    if (ovrValid) begin pendM = 1; pendSegM = ovrSeg; end
    if (segWrEn) segM[segWrSel] = segWrData;
  endtask

  task automatic step(string tag, bit rv, bit [1:0] k, bit bp, bit [15:0] off,
                      bit ov = 0, bit [1:0] os = 0,
                      bit we = 0, bit [1:0] ws = 0, bit [15:0] wd = 0);
    refValid = rv; refKind = k; useBp = bp; offset = off;
    ovrValid = ov; ovrSeg = os;
    segWrEn = we; segWrSel = ws; segWrData = wd;
    @(posedge clk);
    model();
    @(negedge clk);
    chk(tag, "addrValid", int'(addrValid), int'(expValid));
    chk(tag, "physAddr", int'(physAddr), expAddr);
    chk(tag, "segUsed", int'(segUsed), expSeg);
  endtask

  task automatic wr(bit [1:0] s, bit [15:0] d);
    step("R10", 0, 0, 0, 0, 0, 0, 1, s, d);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) segM[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1", "addrValid", int'(addrValid), 0);
    rstN = 1'b1;
    step("R1", 1, 1, 0, 16'h1234);
    step("R12", 0, 0, 0, 16'h9999);
    wr(2'b01, 16'h2000);
    wr(2'b10, 16'h3000);
    wr(2'b00, 16'h4000);
    step("R10", 1, 1, 0, 16'h0001, 0, 0, 1, 2'b11, 16'h123A);
    step("R4", 1, 1, 0, 16'h341B);
    step("R5", 1, 1, 1, 16'h0010);
    step("R3", 1, 0, 0, 16'hFFFF);
    step("R6", 1, 2, 0, 16'h00FE);
    step("R7", 1, 3, 0, 16'h0100);
    step("R8", 0, 0, 0, 0, 1, 2'b01);
    step("R8", 1, 1, 0, 16'h0042);
    step("R9", 1, 1, 0, 16'h0042);
    step("R8", 0, 0, 0, 0, 1, 2'b00);
    step("R8", 1, 1, 1, 16'h0050);
    step("R6", 0, 0, 0, 0, 1, 2'b11);
    step("R6", 1, 2, 1, 16'h0060);
    step("R9", 1, 1, 1, 16'h0060);
    step("R3", 0, 0, 0, 0, 1, 2'b00);
    step("R3", 1, 0, 0, 16'h0070);
    step("R3", 1, 1, 0, 16'h0070);
    step("R7", 0, 0, 0, 0, 1, 2'b01);
    step("R7", 1, 3, 0, 16'h0080);
    step("R9", 1, 1, 0, 16'h0080);
    step("R9", 1, 1, 0, 16'h0090, 1, 2'b01);
    step("R9", 1, 1, 0, 16'h0090);
    wr(2'b00, 16'hFFFF);
    step("R11", 1, 3, 0, 16'hFFFF);
    step("R12", 0, 0, 0, 16'h1111);
    step("R12", 0, 1, 1, 16'h2222);
    for (int n = 0; n < 400; n++) begin
      step("R2", $urandom_range(0, 3) != 0, 2'($urandom), 1'($urandom), 16'($urandom),
           $urandom_range(0, 4) == 0, 2'($urandom),
           $urandom_range(0, 5) == 0, 2'($urandom), 16'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule